// File: doc/BRIEF.md
# Single-Precision to Signed Integer Converter

This block takes a 128-bit vector of packed single-precision floating-point values and turns its low lanes into signed 32-bit integers. In packed mode the two lowest lanes are converted side by side and returned as a 64-bit pair. In scalar mode only lane 0 is converted, and the upper half of the result is cleared.

Each operation carries its own truncate select. When it is set, the conversion rounds toward zero. When it is clear, the conversion follows a 2-bit rounding-control input. Any lane that is not a number, is infinite, or rounds to a value outside the signed 32-bit range returns the single integer pattern 0x80000000. Such a lane raises the invalid flag. When a fraction is thrown away on a valid conversion, the inexact flag is raised. The result and both flags are registered and appear, together with a valid strobe, one clock after the request.

Top module: `fp2int_cvt`

## Requirements
- R1: With `in_packed`=1, lane 0 (`in_vec[31:0]`) converts to `out_result[31:0]` and lane 1 (`in_vec[63:32]`) converts to `out_result[63:32]`.
- R2: With `in_packed`=0, only lane 0 converts into `out_result[31:0]`. `out_result[63:32]` is 0, and lanes 1 to 3 have no effect on the result or on either flag.
- R3: With `in_trunc`=0, `rc_mode` selects the rounding: 2'b00 nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, 2'b11 toward zero.
- R4: With `in_trunc`=1, every lane rounds toward zero, whatever the value of `rc_mode`.
- R5: A lane whose exponent field is all ones (NaN or infinity), or whose rounded value lies outside [-2^31, 2^31-1], gives 0x80000000 and sets `out_invalid`. An input of exactly -2^31 gives 0x80000000 without invalid.
- R6: A nonzero denormal input gives 0 under nearest and toward-zero rounding. Under rounding away from zero in the direction of its sign it gives +1 or -1. In every case it sets inexact.
- R7: `out_inexact` is 1 only when an active lane discarded a nonzero fraction and no active lane was invalid.
- R8: `out_valid` is `in_valid` delayed by one clock. On a clock without `in_valid`, the result and flags keep their values.
- R9: After reset, `out_valid`, `out_result`, `out_inexact` and `out_invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one conversion per clock |
| in_vec | input | 128 | Four packed single-precision lanes, lane 0 in the low bits |
| in_packed | input | 1 | 1 converts lanes 0 and 1, 0 converts lane 0 only |
| in_trunc | input | 1 | Forces round toward zero for this request |
| rc_mode | input | 2 | Rounding control used when `in_trunc` is 0 |
| out_valid | output | 1 | Result strobe, one clock after the request |
| out_result | output | 64 | Converted integers, lane 1 in the high half |
| out_inexact | output | 1 | A fraction was discarded and no lane was invalid |
| out_invalid | output | 1 | An active lane was NaN, infinite or out of range |

## Verification
Two functions can land in the same cycle and compete for the flags: one lane reports an invalid condition while the other lane discards a fraction. The bench provokes this in packed mode. Lane 1 is built from lane 0 with a perturbed exponent, so the sweep keeps pairing a rounded lane with a saturated one. Each such cycle is judged against the rule that invalid wins and inexact is cleared. In scalar mode, lane 1 carries a NaN to show that an inactive lane cannot cause the conflict.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;

    localparam int FP_W      = 32;
    localparam int EXP_W     = 8;
    localparam int MAN_W     = 23;
    localparam int INT_W     = 32;
    localparam int EXP_BIAS  = 127;
    localparam int FRAC_KEEP = 9;
    // below this exponent the magnitude is under 2^-9: all bits land in sticky
    localparam int TINY_EXP  = EXP_BIAS - FRAC_KEEP;
    // exponent of 2^31, the first magnitude outside the positive range
    localparam int SAT_EXP   = EXP_BIAS + INT_W - 1;
    localparam int FX_W      = 2 * INT_W;

    typedef enum logic [1:0] {
        RC_NEAR = 2'b00,
        RC_DOWN = 2'b01,
        RC_UP   = 2'b10,
        RC_ZERO = 2'b11
    } rc_e;

    typedef struct packed {
        logic             sign;
        logic [INT_W-1:0] ip;
        logic             guard;
        logic             sticky;
        logic             ovf;
        logic             neg_min;
    } align_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             inexact;
        logic             invalid;
    } lane_res_t;

endpackage

// File: rtl/fp2int_align.sv
module fp2int_align
    import fp2int_pkg::*;
(
    input  logic [FP_W-1:0] fp,
    output align_t          al
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic [FX_W-1:0]  fx;

    assign exp_f = fp[FP_W-2 -: EXP_W];
    assign man_f = fp[MAN_W-1:0];

    always_comb begin
        al      = '0;
        al.sign = fp[FP_W-1];
        fx      = '0;
        if (exp_f > EXP_W'(SAT_EXP)) begin
            al.ovf = 1'b1;
        end else if (exp_f == EXP_W'(SAT_EXP)) begin
            if (fp[FP_W-1] && (man_f == '0)) begin
                al.neg_min = 1'b1;
            end else begin
                al.ovf = 1'b1;
            end
        end else if ((exp_f == '0) && (man_f == '0)) begin
            al.ip = '0;
        end else if (exp_f < EXP_W'(TINY_EXP)) begin
            // tiny normals and denormals: nonzero, below the guard position
            al.sticky = 1'b1;
        end else begin
            // fixed point with INT_W fraction bits
            fx        = FX_W'({1'b1, man_f}) << (exp_f - EXP_W'(TINY_EXP));
            al.ip     = fx[FX_W-1:INT_W];
            al.guard  = fx[INT_W-1];
            al.sticky = |fx[INT_W-2:0];
        end
    end

endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
    import fp2int_pkg::*;
(
    input  align_t     al,
    input  rc_e        mode,
    output lane_res_t  res
);

    logic             lost;
    logic             inc;
    logic [INT_W-1:0] mag;

    assign lost = al.guard | al.sticky;

    always_comb begin
        unique case (mode)
            RC_NEAR: inc = al.guard & (al.sticky | al.ip[0]);
            RC_DOWN: inc = lost & al.sign;
            RC_UP:   inc = lost & ~al.sign;
            default: inc = 1'b0;
        endcase
    end

    // rounding only happens below 2^23, so the increment cannot leave the range
    assign mag = al.ip + INT_W'(inc);

    always_comb begin
        res = '0;
        if (al.ovf) begin
            res.value   = {1'b1, {(INT_W-1){1'b0}}};
            res.invalid = 1'b1;
        end else if (al.neg_min) begin
            res.value   = {1'b1, {(INT_W-1){1'b0}}};
        end else begin
            res.value   = al.sign ? (~mag + 1'b1) : mag;
            res.inexact = lost;
        end
    end

endmodule

// File: rtl/fp2int_cvt.sv
module fp2int_cvt
    import fp2int_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int VEC_W     = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [VEC_W-1:0]           in_vec,
    input  logic                       in_packed,
    input  logic                       in_trunc,
    input  logic [1:0]                 rc_mode,
    output logic                       out_valid,
    output logic [NUM_LANES*INT_W-1:0] out_result,
    output logic                       out_inexact,
    output logic                       out_invalid
);

    localparam int RES_W = NUM_LANES * INT_W;

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] result;
        logic             inexact;
        logic             invalid;
    } state_t;

    state_t    st_d, st_q;
    rc_e       eff_mode;
    align_t    al_w   [NUM_LANES];
    lane_res_t lane_w [NUM_LANES];

    assign eff_mode = in_trunc ? RC_ZERO : rc_e'(rc_mode);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        fp2int_align u_align (
            .fp (in_vec[i*FP_W +: FP_W]),
            .al (al_w[i])
        );
        fp2int_round u_round (
            .al   (al_w[i]),
            .mode (eff_mode),
            .res  (lane_w[i])
        );
    end

    always_comb begin
        logic any_inv;
        logic any_inx;
        st_d       = st_q;
        st_d.valid = in_valid;
        any_inv    = 1'b0;
        any_inx    = 1'b0;
        if (in_valid) begin
            for (int i = 0; i < NUM_LANES; i++) begin
                if ((i == 0) || in_packed) begin
                    st_d.result[i*INT_W +: INT_W] = lane_w[i].value;
                    any_inv = any_inv | lane_w[i].invalid;
                    any_inx = any_inx | lane_w[i].inexact;
                end else begin
                    st_d.result[i*INT_W +: INT_W] = '0;
                end
            end
            st_d.invalid = any_inv;
            st_d.inexact = any_inx & ~any_inv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_result  = st_q.result;
    assign out_inexact = st_q.inexact;
    assign out_invalid = st_q.invalid;

    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(out_result) && $stable(out_invalid) && $stable(out_inexact)));

    assert_scalar_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !in_packed) |-> (out_result[RES_W-1:INT_W] == '0));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_inexact && out_invalid));

    assert_nan_inf_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && ($past(in_vec[FP_W-2 -: EXP_W]) == '1))
        |-> (out_invalid && (out_result[INT_W-1:0] == {1'b1, {(INT_W-1){1'b0}}})));

endmodule

// File: tb/tb_fp2int_cvt.sv
`timescale 1ns/1ps
module tb_fp2int_cvt;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_vec = '0;
    logic         in_packed = 1'b0;
    logic         in_trunc = 1'b0;
    logic [1:0]   rc_mode = 2'b00;
    logic         out_valid;
    logic [63:0]  out_result;
    logic         out_inexact;
    logic         out_invalid;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fp2int_cvt dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .in_packed(in_packed), .in_trunc(in_trunc), .rc_mode(rc_mode),
        .out_valid(out_valid), .out_result(out_result),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    // reference: {invalid, inexact, value}, computed with real arithmetic
    function automatic logic [33:0] ref_cvt(input logic [31:0] f, input int md);
        int  e;
        real v, fl, r, d;
        e = int'(f[30:23]);
        if (e == 255) return {1'b1, 1'b0, 32'h8000_0000};
        if (e == 0) v = real'(f[22:0]) * (2.0 ** (-149));
        else        v = (real'(f[22:0]) + 8388608.0) * (2.0 ** (e - 150));
        if (f[31]) v = -v;
        fl = $floor(v);
        case (md)
            0: begin
                d = v - fl;
                if (d > 0.5) r = fl + 1.0;
                else if (d < 0.5) r = fl;
                else r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
            end
            1: r = fl;
            2: r = $ceil(v);
            default: r = (v < 0.0) ? $ceil(v) : fl;
        endcase
        if (r > 2147483647.0 || r < -2147483648.0) return {1'b1, 1'b0, 32'h8000_0000};
        return {1'b0, (r != v), 32'(longint'(r))};
    endfunction

    function automatic logic [22:0] mpat(input int k);
        case (k)
            0: return 23'h000000;
            1: return 23'h000001;
            2: return 23'h400000;
            3: return 23'h7FFFFF;
            default: return 23'h2AAAAA;
        endcase
    endfunction

    task automatic check(input string req, input logic [66:0] act, input logic [66:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got valid/result/inx/inv=%h expected %h", req, act, exp_v);
        end
    endtask

    task automatic apply(input logic [31:0] f0, input logic [31:0] f1, input bit pk,
                         input bit tr, input logic [1:0] rc, input string req);
        logic [33:0] r0, r1;
        logic [63:0] exp_res;
        logic        exp_inv, exp_inx;
        int          md;
        md = tr ? 3 : int'(rc);
        r0 = ref_cvt(f0, md);
        r1 = ref_cvt(f1, md);
        if (pk) begin
            exp_res = {r1[31:0], r0[31:0]};
            exp_inv = r0[33] | r1[33];
            exp_inx = (r0[32] | r1[32]) & ~exp_inv;   // R7 rule across lanes
        end else begin
            exp_res = {32'h0, r0[31:0]};
            exp_inv = r0[33];
            exp_inx = r0[32];
        end
        in_vec    = {32'hFFC0_0000, 32'h7F80_0000, f1, f0};
        in_packed = pk;
        in_trunc  = tr;
        rc_mode   = rc;
        in_valid  = 1'b1;
        @(negedge clk);
        check(req, {out_valid, out_result, out_inexact, out_invalid},
              {1'b1, exp_res, exp_inx, exp_inv});
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", {out_valid, out_result, out_inexact, out_invalid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {out_valid, out_result, out_inexact, out_invalid}, '0);

        // directed corners
        apply(32'hCF00_0000, 32'h4F00_0000, 1'b0, 1'b0, 2'b00, "R5");   // -2^31 exact
        apply(32'h4F00_0000, 32'h0, 1'b0, 1'b0, 2'b00, "R5");           // 2^31 invalid
        apply(32'h0000_0001, 32'h8000_0001, 1'b1, 1'b0, 2'b10, "R6");   // denormals, up
        apply(32'h0000_0001, 32'h8000_0001, 1'b1, 1'b0, 2'b01, "R6");   // denormals, down
        apply(32'h3FC0_0000, 32'h4020_0000, 1'b1, 1'b0, 2'b00, "R3");   // 1.5, 2.5 ties
        apply(32'hBFC0_0000, 32'h3FC0_0000, 1'b1, 1'b1, 2'b10, "R4");   // trunc over up
        apply(32'h3FC0_0000, 32'h7FC0_0000, 1'b1, 1'b0, 2'b00, "R7");   // inexact vs NaN

        // R8: idle cycle holds outputs
        begin
            logic [63:0] held;
            logic [1:0]  hflags;
            held   = out_result;
            hflags = {out_inexact, out_invalid};
            in_vec = {4{32'h4000_0000}};
            @(negedge clk);
            check("R8", {out_valid, out_result, out_inexact, out_invalid}, {1'b0, held, hflags});
        end

        // sweep: R1 packed, R2 scalar, R3 rounding, R4 truncate, R5 saturate, R6 denormal
        for (int e = 0; e < 256; e++) begin
            for (int mi = 0; mi < 5; mi++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    for (int md = 0; md < 8; md++) begin
                        logic [31:0] f0, f1;
                        bit          pk;
                        string       req;
                        pk = ((e + mi + sg + md) % 2) == 1;
                        f0 = {sg[0], e[7:0], mpat(mi)};
                        f1 = pk ? {~sg[0], e[7:0] ^ 8'h05, mpat((mi + 2) % 5)} : 32'h7FC0_0000;
                        if (e == 255 || e >= 158) req = "R5";
                        else if (e == 0) req = "R6";
                        else if (md >= 4) req = "R4";
                        else if (pk) req = "R1";
                        else req = "R2/R3";
                        apply(f0, f1, pk, md[2], md[1:0], req);
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule